// File: doc/BRIEF.md
# Half-Word-Lane Static Memory Core

This block is a synthesizable word-organised memory with the control behaviour of an asynchronous static RAM. Two chip selects of opposite polarity choose the device. An active-low write strobe chooses between read and write. An active-low output strobe gates reads. Two active-low lane enables pick which 16-bit half of the 32-bit word takes part in an access.

The control inputs are decoded into four conditions: standby, read, write and active-but-quiet. Each half-word lane gets its own drive-enable output, which stands in for the lane's three-state pins. Each lane also gets its own slice of the read-data bus.

A rising clock edge stands in for the terminating edge of the write pulse, so stores commit on that edge. Read data is registered on the same clock. The drive enables are pure decode of the present controls, so the pins release at once when the controls change.

The full-size configuration uses a 17-bit address, giving 131,072 words. The address width is a parameter, and its default is smaller so the storage stays compact at elaboration.

Top module: `sram_hw32`

## Requirements
- R1: The device is selected only when `sel_n` = 0 and `sel` = 1. In every other case `drv` = 2'b00, `rdata` = 0, and no location is written, whatever the other inputs are.
- R2: A read condition is selection with `wr_n` = 1 and `out_n` = 0. In a read condition, `drv[i]` = 1 exactly for each lane with `lane_n[i]` = 0. A driven lane of `rdata` shows the stored half-word at `addr`, captured at the first clock edge of the read condition. An undriven lane of `rdata` reads 0.
- R3: A write condition is selection with `wr_n` = 0. At each clock edge in a write condition, `wdata` is stored at `addr` into every lane with `lane_n[i]` = 0. The value of `out_n` has no effect on a write. A read in the cycle after a write returns the new data.
- R4: Throughout a write condition, `drv` = 2'b00.
- R5: Lane encoding: `lane_n[0]` governs bits 15:0 and `lane_n[1]` governs bits 31:16. With `lane_n` = 2'b00 the access covers the full 32-bit word. A half-word write leaves the other half of the word unchanged.
- R6: With `lane_n` = 2'b11, nothing is driven and nothing is stored, even while the device is selected.
- R7: While the device is selected with `out_n` = 1 and `wr_n` = 1, `drv` = 2'b00 and `rdata` = 0.
- R8: While a read condition is held, changing only `addr` starts a new read. `rdata` shows the new location's data one clock edge later.
- R9: `drv` follows the controls combinationally. It drops in the same cycle as deselection, as `out_n` rising, or as `wr_n` falling, with no clock edge in between.
- R10: After reset, `rdata` = 0 and `drv` = 2'b00 until a read condition is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; write commit and read capture edge |
| rst_n | input | 1 | Active-low asynchronous reset of the read register |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write strobe |
| out_n | input | 1 | Active-low output strobe |
| lane_n | input | 2 | Active-low lane enables; bit 0 = bits 15:0, bit 1 = bits 31:16 |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; undriven lanes read 0 |
| drv | output | 2 | Per-lane drive enable standing in for the three-state pins |

## Verification
Two functions meet in one cycle in two places. The first is a write committing on one edge while a read of the same word captures on the very next edge. The bench provokes this by writing and then reading the same address back to back, and judges it against a sparse reference model updated per lane. The second is a read-to-write turnaround: the bench drops `wr_n` in the middle of a held read. In that same cycle, before any clock edge, both drive enables must already be low and the read bus must be 0.

// File: rtl/sram_hw32.sv
module sram_hw32 #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              wr_n,
  input  logic              out_n,
  input  logic [DATA_W/LANE_W-1:0] lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W/LANE_W-1:0] drv
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic chosen, rd_go, wr_go;

  assign chosen = !sel_n && sel;
  assign rd_go  = chosen && wr_n && !out_n;
  assign wr_go  = chosen && !wr_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] hold;

    always_ff @(posedge clk)
      if (wr_go && !lane_n[g])
        store[addr] <= wdata[g*LANE_W +: LANE_W];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        hold <= '0;
      else if (rd_go)
        hold <= store[addr];

    assign drv[g] = rd_go && !lane_n[g];
    assign rdata[g*LANE_W +: LANE_W] = drv[g] ? hold : '0;
  end
endmodule

// File: rtl/sram_hw32_chk.sv
module sram_hw32_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LANE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              sel,
  input logic              wr_n,
  input logic              out_n,
  input logic [DATA_W/LANE_W-1:0] lane_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W/LANE_W-1:0] drv
);
  logic reading;
  assign reading = !sel_n && sel && wr_n && !out_n;

  p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || !sel) |-> (drv == '0 && rdata == '0));

  p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && !wr_n) |-> (drv == '0));

  p_lane_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((drv & lane_n) == '0));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && wr_n && out_n) |-> (drv == '0 && rdata == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && $past(reading) && $past(reading, 2) &&
     $past(addr) == $past(addr, 2) && $stable(lane_n)) |-> $stable(rdata));
endmodule

bind sram_hw32 sram_hw32_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .wr_n(wr_n),
  .out_n(out_n), .lane_n(lane_n), .addr(addr), .rdata(rdata), .drv(drv)
);

// File: tb/test_sram_hw32.sv
`timescale 1ns/100ps
module test_sram_hw32;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0;
  logic sel_n = 1, sel = 0, wr_n = 1, out_n = 1;
  logic [1:0] lane_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0] drv;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] mdl_lo [int];
  logic [15:0] mdl_hi [int];

  always #2.5 clk = ~clk;

  sram_hw32 #(.ADDR_W(AW)) i_sram_hw32 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .wr_n(wr_n),
    .out_n(out_n), .lane_n(lane_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .drv(drv)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(int a, logic [1:0] ln);
    logic [31:0] w = '0;
    if (!ln[0]) w[15:0]  = mdl_lo[a];
    if (!ln[1]) w[31:16] = mdl_hi[a];
    return w;
  endfunction

  task automatic go_idle();
    @(negedge clk);
    sel_n = 0; sel = 1; wr_n = 1; out_n = 1; lane_n = 2'b11;
  endtask

  task automatic do_write(int a, logic [31:0] d, logic [1:0] ln, logic oe);
    @(negedge clk);
    sel_n = 0; sel = 1; wr_n = 0; out_n = oe; lane_n = ln;
    addr = a[AW-1:0]; wdata = d;
    #1 chk("R4 drive off during write", {30'd0, drv}, 32'd0);
    @(posedge clk);
    if (!ln[0]) mdl_lo[a] = d[15:0];
    if (!ln[1]) mdl_hi[a] = d[31:16];
  endtask

  task automatic do_read(string req, int a, logic [1:0] ln);
    @(negedge clk);
    sel_n = 0; sel = 1; wr_n = 1; out_n = 0; lane_n = ln; addr = a[AW-1:0];
    #1 chk({req, " drive"}, {30'd0, drv}, {30'd0, ~ln});
    @(posedge clk);
    #1 chk({req, " data"}, rdata, model_word(a, ln));
  endtask

  task automatic t_reset();
    chk("R10 reset drv", {30'd0, drv}, 32'd0);
    chk("R10 reset rdata", rdata, 32'd0);
  endtask

  task automatic t_full();
    do_write(3, 32'hDEAD_BEEF, 2'b00, 1'b1);
    do_write(7, 32'h1234_5678, 2'b00, 1'b1);
    do_write(1023, 32'hA5A5_5A5A, 2'b00, 1'b1);
    do_read("R3 R5 full word", 3, 2'b00);
    do_read("R3 R5 full word", 7, 2'b00);
    do_read("R5 top address", 1023, 2'b00);
  endtask

  task automatic t_half();
    do_write(3, 32'h0000_C0DE, 2'b10, 1'b1);
    do_read("R5 low write keeps high", 3, 2'b00);
    do_write(7, 32'hFACE_0000, 2'b01, 1'b0);
    do_read("R3 out_n ignored on write, R5 high lane", 7, 2'b00);
    do_read("R2 low lane only", 7, 2'b10);
    do_read("R2 high lane only", 3, 2'b01);
  endtask

  task automatic t_none();
    do_write(3, 32'h1111_2222, 2'b11, 1'b1);
    do_read("R6 no-lane write stores nothing", 3, 2'b00);
    do_read("R6 no-lane read drives nothing", 7, 2'b11);
  endtask

  task automatic t_standby();
    @(negedge clk);
    sel_n = 1; sel = 1; wr_n = 0; out_n = 0; lane_n = 2'b00; addr = 7; wdata = 32'h9999_9999;
    #1 chk("R1 sel_n high drv", {30'd0, drv}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    sel_n = 0; sel = 0;
    #1 chk("R1 sel low drv", {30'd0, drv}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    wr_n = 1;
    #1 chk("R1 deselected read drv", {30'd0, drv}, 32'd0);
    @(posedge clk);
    #1 chk("R1 deselected rdata", rdata, 32'd0);
    do_read("R1 standby write ignored", 7, 2'b00);
  endtask

  task automatic t_idle();
    do_read("R2 prime", 3, 2'b00);
    @(negedge clk);
    out_n = 1;
    #1 chk("R7 R9 out_n high drv", {30'd0, drv}, 32'd0);
    chk("R7 out_n high rdata", rdata, 32'd0);
    @(posedge clk);
    #1 chk("R7 still quiet", rdata, 32'd0);
  endtask

  task automatic t_stream();
    int seq [4] = '{3, 7, 1023, 3};
    @(negedge clk);
    sel_n = 0; sel = 1; wr_n = 1; out_n = 0; lane_n = 2'b00;
    foreach (seq[i]) begin
      if (i != 0) @(negedge clk);
      addr = seq[i][AW-1:0];
      @(posedge clk);
      #1 chk("R8 address stream", rdata, model_word(seq[i], 2'b00));
    end
  endtask

  task automatic t_turnaround();
    do_read("R2 prime", 1023, 2'b00);
    @(negedge clk);
    wr_n = 0; lane_n = 2'b00; wdata = 32'h0BAD_F00D;
    #1 chk("R9 write drops drv", {30'd0, drv}, 32'd0);
    chk("R9 write zeroes rdata", rdata, 32'd0);
    @(posedge clk);
    mdl_lo[1023] = 16'hF00D; mdl_hi[1023] = 16'h0BAD;
    do_read("R3 read right after write", 1023, 2'b00);
    @(negedge clk);
    sel = 0;
    #1 chk("R9 deselect drops drv", {30'd0, drv}, 32'd0);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1;
    t_reset();
    t_full();
    t_half();
    t_none();
    t_standby();
    t_idle();
    t_stream();
    t_turnaround();
    go_idle();
    done = 1;
    report();
  end
endmodule